// File: doc/BRIEF.md
# Pulse-Width Lock Monitor for a Phase-Frequency Detector

This block watches the pump-up and pump-down outputs of an edge-triggered phase-frequency detector and decides whether the loop is in lock. It measures each error pulse in system-clock cycles. A short pulse is the residual backlash that every detector emits at lock, and it is tolerated. A pulse that grows to a programmable number of cycles means the phase error is too large. Software sets that number from the largest phase error it accepts: the error as a fraction of a full turn, times the reference period. For example, a tenth of a turn at a 500 ns period allows 50 ns. The limit must stay above the backlash width. The measurement is not meaningful for an exclusive-OR detector, whose outputs are not error pulses.

Two flags come out. The raw flag drops on every clock that finds an over-limit pulse. The stable flag drops with it and rises again only after a programmable number of clean cycles. This turns the pulsed indication into a steady level. After reset both flags read unlocked until one full hold interval has passed.

Top module: `pulse_lock_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `lock_raw` and `lock_stable` are 0 after that edge.
- R2: A pulse is a run of consecutive sampled cycles in which `up_i` or `dn_i` (either one or both) is 1. A single cycle with both inputs low ends the run, and the next active cycle starts a new run of length 1.
- R3: A pulse whose length stays below `width_limit` cycles has no effect on either flag. Its active cycles count as clean cycles.
- R4: A pulse becomes a violation at the edge that samples its `width_limit`-th cycle, and at every later edge of the same pulse. `lock_raw` and `lock_stable` both read 0 after each such edge.
- R5: With `width_limit` equal to 0, every active cycle is a violation, including a pulse one cycle long.
- R6: Once the block has qualified after reset, `lock_raw` reads 1 after every edge that samples a clean cycle.
- R7: `lock_stable` reads 1 only after `hold_len` consecutive clean cycles with no violation between them, and every violation restarts that count. With `hold_len` equal to 0, the first clean cycle is enough.
- R8: After reset, `lock_raw` stays 0 through clean cycles until `lock_stable` first rises. Both then rise at the same edge.
- R9: When a violation falls on the edge that would complete the hold interval, the violation wins: both flags read 0 and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | Pump-up pulse from the detector, synchronous to clk |
| dn_i | input | 1 | Pump-down pulse from the detector, synchronous to clk |
| width_limit | input | CNT_W | Pulse length, in cycles, that counts as out of lock |
| hold_len | input | HOLD_W | Clean cycles needed before the stable flag rises |
| lock_raw | output | 1 | Per-cycle lock indication |
| lock_stable | output | 1 | Lock indication held through the hold interval |

## Verification
The width meter and the hold timer can act on the same edge. One pulse reaches the limit on exactly the cycle that would complete the hold count. Another pulse stays just under the limit, and its active cycles must still advance the hold count. The bench provokes the collision on purpose: after a violation, it places a pulse so that its limit-reaching cycle is the `hold_len`-th clean cycle. After that edge it expects both flags low and a fresh hold interval. Sweeps over every limit and pulse length on both sides of the boundary are compared cycle by cycle against an arithmetic expectation.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

    // Outcome of one sampled cycle of the width meter
    typedef struct packed {
        logic active;   // up or down asserted this cycle
        logic over;     // pulse has reached the width limit
    } pulse_eval_t;

    // Qualification state of the hold timer
    typedef enum logic [1:0] {
        HS_STARTUP = 2'd0,  // not yet qualified since reset
        HS_LOCKED  = 2'd1,  // hold interval completed
        HS_HOLDING = 2'd2   // qualified earlier, waiting out a hold interval
    } hold_state_t;

    // Increment that sticks at the all-ones value
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] vmax);
        return (v >= vmax) ? vmax : v + 32'd1;
    endfunction

endpackage

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
    import lockmon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic [CNT_W-1:0] width_limit,
    output pulse_eval_t      eval_o
);
    localparam logic [31:0] RUN_MAX = 32'((64'd1 << CNT_W) - 64'd1);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   len_now;
    logic             active;

    // R2: either input (or both) keeps the pulse running
    assign active  = up_i | dn_i;
    // Length of the pulse including the cycle being sampled
    assign len_now = {1'b0, run_q} + {{CNT_W{1'b0}}, 1'b1};

    // R4/R5: the cycle whose length reaches the limit is a violation
    always_comb begin
        eval_o.active = active;
        eval_o.over   = active && (len_now >= {1'b0, width_limit});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!active) begin
            run_q <= '0;
        end else begin
            run_q <= CNT_W'(sat_inc(32'(run_q), RUN_MAX));
        end
    end

endmodule

// File: rtl/lock_hold_timer.sv
module lock_hold_timer
    import lockmon_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pulse_eval_t       eval_i,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              raw_o,
    output logic              stable_o
);
    localparam logic [31:0] HOLD_MAX = 32'((64'd1 << HOLD_W) - 64'd1);

    hold_state_t       state_q;
    logic [HOLD_W-1:0] clean_q;
    logic [HOLD_W:0]   clean_now;
    logic              qualifies;
    logic              raw_q;

    assign clean_now = {1'b0, clean_q} + {{HOLD_W{1'b0}}, 1'b1};
    // R7: this clean cycle completes the hold interval
    assign qualifies = clean_now >= {1'b0, hold_len};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_STARTUP;   // R1
            clean_q <= '0;
            raw_q   <= 1'b0;
        end else if (eval_i.over) begin
            // R4/R9: a violation beats a completing hold interval
            clean_q <= '0;
            raw_q   <= 1'b0;
            if (state_q != HS_STARTUP) begin
                state_q <= HS_HOLDING;
            end
        end else begin
            clean_q <= HOLD_W'(sat_inc(32'(clean_q), HOLD_MAX));
            // R6/R8: raw follows clean cycles once qualified
            raw_q   <= (state_q != HS_STARTUP) || qualifies;
            if (qualifies) begin
                state_q <= HS_LOCKED;
            end
        end
    end

    assign raw_o    = raw_q;
    assign stable_o = (state_q == HS_LOCKED);

endmodule

// File: rtl/pulse_lock_monitor.sv
module pulse_lock_monitor
    import lockmon_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic [CNT_W-1:0]  width_limit,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              lock_raw,
    output logic              lock_stable
);
    pulse_eval_t eval_w;

    pulse_width_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst         (rst),
        .up_i        (up_i),
        .dn_i        (dn_i),
        .width_limit (width_limit),
        .eval_o      (eval_w)
    );

    lock_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .eval_i   (eval_w),
        .hold_len (hold_len),
        .raw_o    (lock_raw),
        .stable_o (lock_stable)
    );

endmodule

// File: rtl/pulse_lock_checker.sv
module pulse_lock_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             up_i,
    input logic             dn_i,
    input logic [CNT_W-1:0] width_limit,
    input logic             lock_raw,
    input logic             lock_stable
);
    // R1: reset clears both flags
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!lock_raw && !lock_stable));

    // R4/R8: stable never reads high while raw is low
    a_r4_stable_needs_raw: assert property (@(posedge clk) disable iff (rst)
        lock_stable |-> lock_raw);

    // R5: a zero limit turns any active cycle into a violation
    a_r5_zero_limit: assert property (@(posedge clk) disable iff (rst)
        ((width_limit == '0) && (up_i || dn_i)) |=> !lock_raw);

    // R6: an idle cycle keeps a high raw flag high
    a_r6_idle_keeps_raw: assert property (@(posedge clk) disable iff (rst)
        (lock_raw && !up_i && !dn_i) |=> lock_raw);

    // R7: stable only rises together with a high raw flag
    a_r7_rise_with_raw: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_stable) |-> lock_raw);

endmodule

bind pulse_lock_monitor pulse_lock_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .up_i        (up_i),
    .dn_i        (dn_i),
    .width_limit (width_limit),
    .lock_raw    (lock_raw),
    .lock_stable (lock_stable)
);

// File: tb/pulse_lock_monitor_bench.sv
module pulse_lock_monitor_bench;
    localparam int CW = 4;
    localparam int HW = 3;
    localparam int RUN_MAX  = (1 << CW) - 1;
    localparam int HOLD_MAX = (1 << HW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          up_i = 1'b0;
    logic          dn_i = 1'b0;
    logic [CW-1:0] width_limit = '0;
    logic [HW-1:0] hold_len = '0;
    logic          lock_raw;
    logic          lock_stable;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expectation state, derived from the requirements
    int m_run = 0, m_clean = 0, m_state = 0;
    bit m_raw = 0;

    always #5 clk = ~clk;

    pulse_lock_monitor #(.CNT_W(CW), .HOLD_W(HW)) u_pulse_lock_monitor (
        .clk(clk), .rst(rst), .up_i(up_i), .dn_i(dn_i),
        .width_limit(width_limit), .hold_len(hold_len),
        .lock_raw(lock_raw), .lock_stable(lock_stable)
    );

    task automatic model_edge(input bit u, input bit d);
        bit act, over, qual;
        if (rst) begin
            m_run = 0; m_clean = 0; m_state = 0; m_raw = 0;
            return;
        end
        act  = u | d;
        over = act && (m_run + 1 >= int'(width_limit));
        m_run = act ? ((m_run >= RUN_MAX) ? RUN_MAX : m_run + 1) : 0;
        if (over) begin
            m_clean = 0; m_raw = 0;
            if (m_state != 0) m_state = 2;
        end else begin
            qual = (m_clean + 1 >= int'(hold_len));
            m_clean = (m_clean >= HOLD_MAX) ? HOLD_MAX : m_clean + 1;
            m_raw = (m_state != 0) || qual;
            if (qual) m_state = 1;
        end
    endtask

    // drive at the falling edge, sample after the next falling edge
    task automatic step(input bit u, input bit d, input string tag);
        up_i = u; dn_i = d;
        @(posedge clk);
        model_edge(u, d);
        @(negedge clk);
        checks++;
        if (lock_raw !== m_raw || lock_stable !== (m_state == 1)) begin
            errors++;
            $display("FAIL %s raw=%b stable=%b expected raw=%b stable=%b (limit=%0d hold=%0d)",
                     tag, lock_raw, lock_stable, m_raw, (m_state == 1), width_limit, hold_len);
        end
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        step(0, 0, tag);
        step(0, 0, tag);
        rst = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, tag);
    endtask

    // pattern: 0 up only, 1 down only, 2 both, 3 alternating
    task automatic pulse(input int w, input int pat, input string tag);
        for (int i = 0; i < w; i++) begin
            case (pat)
                0: step(1, 0, tag);
                1: step(0, 1, tag);
                2: step(1, 1, tag);
                default: step(i[0], ~i[0], tag);
            endcase
        end
    endtask

    initial begin
        @(negedge clk);
        width_limit = 4'd3; hold_len = 3'd3;
        do_reset("R1");

        // hold-length sweep: startup qualification and re-qualification
        for (int l = 0; l <= 4; l++) begin
            hold_len = HW'(l); width_limit = 4'd3;
            do_reset("R1");
            idle(6, "R8");
            pulse(4, 0, "R4");
            idle(8, "R6_R7");
            pulse(3, 1, "R4");
            pulse(1, 2, "R3");
            idle(6, "R7");
        end

        // limit versus pulse length, every pattern
        for (int t = 0; t <= 6; t++) begin
            for (int w = 1; w <= 8; w++) begin
                width_limit = CW'(t); hold_len = 3'd2;
                do_reset("R1");
                idle(3, "R8");
                pulse(w, (t + w) % 4, (t == 0) ? "R5" : "R3_R4");
                idle(4, "R6_R7");
            end
        end

        // pulses separated by one idle cycle are separate runs
        width_limit = 4'd3; hold_len = 3'd4;
        do_reset("R1");
        idle(5, "R8");
        for (int k = 0; k < 6; k++) begin
            pulse(2, k % 4, "R2");
            idle(1, "R2");
        end
        pulse(6, 3, "R2_R4");
        idle(6, "R7");

        // repeated backlash pulses leave lock untouched
        for (int k = 0; k < 8; k++) begin
            pulse(1 + (k % 2), 2, "R3");
            idle(2, "R3");
        end

        // violation on the cycle that would complete the hold interval
        width_limit = 4'd2; hold_len = 3'd3;
        do_reset("R1");
        idle(4, "R8");
        pulse(2, 0, "R4");
        idle(1, "R9");
        pulse(2, 1, "R9");
        idle(2, "R9");
        idle(3, "R7");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule